// File: doc/BRIEF.md
# Synchronous Burst Cache RAM

This block is a clocked word-wide memory meant to sit behind a processor or a cache controller. Each word carries two byte lanes of nine bits: eight data bits and one parity bit. The address, the three chip enables and the write qualifiers are all captured on the rising clock edge. An access sequence of up to four words can be opened by either of two start strobes. One strobe is meant for the processor and is gated by the primary chip enable. The other is meant for a controller and is never gated.

After a start, a two-bit beat counter walks the low two address bits while the upper bits stay fixed. The walk follows one of two orders, chosen by an input pin: a plain wrapping count, or an XOR sequence. The counter only moves in cycles where the advance input is high. Writes can cover the whole word or be limited to single lanes. Read data is registered and reaches a shared bidirectional data bus through an output enable that acts without waiting for the clock. While the sleep input is high, the block ignores every clock edge and releases the bus.

Top module: `burst_cache_ram`

## Requirements
- R1: After `rst_n` has been low, `dq` stays undriven (all Z), even with `oe` high, until a read access has taken place.
- R2: A high `ctl_start` always opens an access at `addr`. A high `cpu_start` opens one only when `cen_a` is high. A `cpu_start` taken while `cen_a` is low, with `ctl_start` and `adv` both low, changes neither the counter nor the value on `dq`.
- R3: With `burst_mode`=0 (linear), beat k of an access that starts at low bits s uses low bits (s+k) mod 4. The upper address bits keep the values captured at the start.
- R4: With `burst_mode`=1 (interleaved), beat k uses low bits s XOR k. The upper address bits are unchanged.
- R5: Each clock edge with `adv` high and no start, while the block is selected, moves to the next beat and performs one access. An edge with `adv` low and no start performs no access, and `dq` holds its value.
- R6: A start that arrives during an access sequence abandons that sequence and begins again at beat 0 at the new `addr`.
- R7: A start taken while any of `cen_a`, `cen_b`, `cen_c` is low deselects the block. Nothing is written, `dq` is undriven, and `adv` has no effect until the next selected start.
- R8: `gwrite`=1 writes both lanes of the word, whatever the values of `bwe` and `lane_sel`. Lane 0 is `dq[8:0]` and lane 1 is `dq[17:9]`.
- R9: With `gwrite`=0 and `bwe`=1, lane i is written only if `lane_sel[i]`=1, and the other lane keeps its old content. With `gwrite`=0 and `bwe`=0, the access is a read and writes nothing.
- R10: A read access registers the addressed word on its clock edge, and `dq` shows that word after the edge while `oe` is high. After a write access, `dq` is undriven.
- R11: `oe` acts without a clock edge. Taking it low releases `dq` at once, and taking it high drives the registered read word again.
- R12: While `sleep` is high, clock edges have no effect: no write, no start and no beat change. `dq` is undriven during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address, captured on a start |
| cpu_start | input | 1 | Processor start strobe, gated by `cen_a` |
| ctl_start | input | 1 | Controller start strobe, never gated |
| adv | input | 1 | Step to the next beat |
| burst_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| cen_a | input | 1 | Primary chip enable (active high) |
| cen_b | input | 1 | Second chip enable (active high) |
| cen_c | input | 1 | Third chip enable (active high) |
| gwrite | input | 1 | Write all lanes |
| bwe | input | 1 | Enable per-lane writes |
| lane_sel | input | LANES | Lane selects for per-lane writes |
| oe | input | 1 | Output enable, acts without the clock |
| sleep | input | 1 | Ignore clock edges and release the bus |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The bench builds the block with `ADDR_W`=6, so the array holds 64 words. At that size, every word can be filled with a known pattern and checked again after later lane writes. Both burst orders are tried from each of the four starting offsets, with starting addresses whose upper bits are non-zero. This shows that the counter changes only the low two bits. The lane layout is kept at its default of two 9-bit lanes, so tests that write one lane alone cover both parity bits.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   // Low two address bits used on a given beat of a four-beat sequence.
   function automatic logic [1:0] beat_offset(input logic [1:0] first,
                                              input logic [1:0] beat,
                                              input burst_order_e order);
      return (order == ORD_INTERLEAVE) ? (first ^ beat) : (first + beat);
   endfunction

endpackage

// File: rtl/bcr_burst_ctr.sv
module bcr_burst_ctr
   import bcr_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [1:0]   load_val,
   input  burst_order_e order,
   output logic [1:0]   beat,
   output logic [1:0]   nxt_off
);

   logic [1:0] first_q;
   logic [1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 2'd0;
         beat_q  <= 2'd0;
      end else if (load) begin
         first_q <= load_val;
         beat_q  <= 2'd0;
      end else if (step) begin
         beat_q  <= beat_q + 2'd1;
      end
   end

   assign beat    = beat_q;
   assign nxt_off = beat_offset(first_q, beat_q + 2'd1, order);

endmodule

// File: rtl/bcr_lane_array.sv
module bcr_lane_array #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    acc_en,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      // Read-first: the register takes the content from before this edge.
      always_ff @(posedge clk) begin
         if (acc_en) begin
            rd_q <= mem[acc_addr];
            if (lane_we[l]) mem[acc_addr] <= wdata[l*LANE_W +: LANE_W];
         end
      end

      assign rdata[l*LANE_W +: LANE_W] = rd_q;
   end

endmodule

// File: rtl/burst_cache_ram.sv
module burst_cache_ram
   import bcr_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    cpu_start,
   input  logic                    ctl_start,
   input  logic                    adv,
   input  logic                    burst_mode,
   input  logic                    cen_a,
   input  logic                    cen_b,
   input  logic                    cen_c,
   input  logic                    gwrite,
   input  logic                    bwe,
   input  logic [LANES-1:0]        lane_sel,
   input  logic                    oe,
   input  logic                    sleep,
   inout  tri   [LANES*LANE_W-1:0] dq
);

   localparam int WORD_W = LANES * LANE_W;
   localparam int HI_W   = ADDR_W - 2;

   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr
      $error("burst_cache_ram: ADDR_W must lie in 3..16");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_cache_ram: LANES and LANE_W must be positive");
   end

   logic              chip_on;
   logic              start;
   logic              step;
   logic              wr_req;
   logic              acc_en;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] acc_addr;
   logic [1:0]        ctr_beat;
   logic [1:0]        nxt_off;
   logic [HI_W-1:0]   hi_q;
   logic              sel_q;
   logic              rd_valid_q;
   logic [WORD_W-1:0] rdata;
   logic              drive;

   assign chip_on = cen_a & cen_b & cen_c;
   assign start   = ~sleep & (ctl_start | (cpu_start & cen_a));
   assign step    = ~sleep & ~ctl_start & ~(cpu_start & cen_a) & adv & sel_q;
   assign wr_req  = gwrite | (bwe & (|lane_sel));
   assign acc_en  = (start & chip_on) | step;
   assign acc_addr = start ? addr : {hi_q, nxt_off};
   assign lane_we = acc_en ? ({LANES{gwrite}} | ({LANES{bwe}} & lane_sel))
                           : '0;

   bcr_burst_ctr u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .step     (step),
      .load_val (addr[1:0]),
      .order    (burst_order_e'(burst_mode)),
      .beat     (ctr_beat),
      .nxt_off  (nxt_off)
   );

   bcr_lane_array #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_array (
      .clk      (clk),
      .acc_en   (acc_en),
      .acc_addr (acc_addr),
      .lane_we  (lane_we),
      .wdata    (dq),
      .rdata    (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q       <= '0;
         sel_q      <= 1'b0;
         rd_valid_q <= 1'b0;
      end else if (start) begin
         hi_q       <= addr[ADDR_W-1:2];
         sel_q      <= chip_on;
         rd_valid_q <= chip_on & ~wr_req;
      end else if (step) begin
         rd_valid_q <= ~wr_req;
      end
   end

   assign drive = oe & rd_valid_q & ~sleep;
   assign dq    = drive ? rdata : {WORD_W{1'bz}};

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
   parameter int WORD_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep,
   input logic              cpu_start,
   input logic              ctl_start,
   input logic              adv,
   input logic              cen_a,
   input logic              cen_b,
   input logic              cen_c,
   input logic [1:0]        beat,
   input logic              sel,
   input logic              rd_valid,
   input logic [WORD_W-1:0] rdata
);

   assert_sleep_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(beat) && $stable(rdata) && $stable(sel));

   assert_cpu_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && cpu_start && !cen_a && !ctl_start && !adv)
      |=> $stable(beat) && $stable(rdata));

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !cpu_start && !ctl_start && adv && sel)
      |=> beat == $past(beat) + 2'd1);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_start && !(cpu_start && cen_a) && !adv)
      |=> $stable(beat) && $stable(rdata));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (ctl_start || (cpu_start && cen_a))) |=> beat == 2'd0);

   assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && ctl_start && !(cen_a && cen_b && cen_c))
      |=> !sel && !rd_valid);

endmodule

bind burst_cache_ram bcr_checker #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep     (sleep),
   .cpu_start (cpu_start),
   .ctl_start (ctl_start),
   .adv       (adv),
   .cen_a     (cen_a),
   .cen_b     (cen_b),
   .cen_c     (cen_c),
   .beat      (ctr_beat),
   .sel       (sel_q),
   .rd_valid  (rd_valid_q),
   .rdata     (rdata)
);

// File: tb/burst_cache_ram_bench.sv
module burst_cache_ram_bench;

   localparam int AW = 6;
   localparam int W  = 18;
   localparam logic [W-1:0] ZZ = {W{1'bz}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          cpu_start = 0, ctl_start = 0, adv = 0, burst_mode = 0;
   logic          cen_a = 1, cen_b = 1, cen_c = 1;
   logic          gwrite = 0, bwe = 0, oe = 0, sleep = 0;
   logic [1:0]    lane_sel = '0;
   logic [W-1:0]  tb_dq = '0;
   logic          tb_drv = 0;
   tri   [W-1:0]  dq;

   logic [W-1:0]  model [64];
   int            n_chk = 0;
   int            n_fail = 0;
   logic          done = 0;

   assign dq = tb_drv ? tb_dq : ZZ;

   always #10 clk = ~clk;

   burst_cache_ram #(.ADDR_W(AW)) u_burst_cache_ram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_start(cpu_start),
      .ctl_start(ctl_start), .adv(adv), .burst_mode(burst_mode),
      .cen_a(cen_a), .cen_b(cen_b), .cen_c(cen_c), .gwrite(gwrite),
      .bwe(bwe), .lane_sel(lane_sel), .oe(oe), .sleep(sleep), .dq(dq)
   );

   task automatic chk(input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      cpu_start = 0; ctl_start = 0; adv = 0; gwrite = 0; bwe = 0;
      lane_sel = '0; tb_drv = 0; cen_a = 1; cen_b = 1; cen_c = 1;
   endtask

   task automatic model_wr(input int a, input logic [W-1:0] d,
                           input logic gw, input logic bw,
                           input logic [1:0] sel);
      for (int l = 0; l < 2; l++)
         if (gw || (bw && sel[l])) model[a][l*9 +: 9] = d[l*9 +: 9];
   endtask

   // single-word write opened by the controller strobe; ends at a negedge
   task automatic wr_word(input int a, input logic [W-1:0] d,
                          input logic gw, input logic bw,
                          input logic [1:0] sel);
      @(negedge clk);
      idle(); oe = 0; ctl_start = 1; addr = AW'(a);
      gwrite = gw; bwe = bw; lane_sel = sel; tb_dq = d; tb_drv = 1;
      @(posedge clk);
      model_wr(a, d, gw, bw, sel);
      @(negedge clk);
      idle();
   endtask

   // single read; data is checked at the negedge after the capturing edge
   task automatic rd_word(input int a, input string req);
      @(negedge clk);
      idle(); oe = 1; ctl_start = 1; addr = AW'(a);
      @(posedge clk);
      @(negedge clk);
      idle();
      chk(req, dq, model[a]);
   endtask

   task automatic t_reset();
      oe = 1;
      #1 chk("R1 bus undriven after reset", dq, ZZ);
   endtask

   task automatic t_fill();
      for (int a = 0; a < 64; a++) wr_word(a, W'(a * 4999 + 18'h15A3), 1, 0, 2'b00);
      rd_word(0, "R8 fill read-back word 0");
      rd_word(63, "R8 fill read-back word 63");
   endtask

   task automatic rd_burst(input int a, input logic ord, input logic use_cpu);
      int base;
      int s;
      base = a & ~3; s = a & 3;
      @(negedge clk);
      idle(); oe = 1; burst_mode = ord; addr = AW'(a);
      if (use_cpu) cpu_start = 1; else ctl_start = 1;
      @(posedge clk);
      @(negedge clk);
      idle(); adv = 1;
      chk(ord ? "R4 interleaved beat 0" : "R3 linear beat 0", dq, model[a]);
      for (int k = 1; k < 4; k++) begin
         int off;
         off = ord ? (s ^ k) : ((s + k) & 3);
         @(posedge clk);
         @(negedge clk);
         chk(ord ? "R4 interleaved beat" : "R3 linear beat", dq, model[base + off]);
      end
      adv = 0;
   endtask

   task automatic t_orders();
      for (int o = 0; o < 2; o++)
         for (int s = 0; s < 4; s++) rd_burst(20 + s + o * 16, o[0], s[0]);
   endtask

   task automatic t_hold();
      rd_burst(33, 0, 0);
      @(negedge clk); idle(); oe = 1; burst_mode = 0; ctl_start = 1; addr = 6'd33;
      @(posedge clk); @(negedge clk); idle();
      @(posedge clk); @(negedge clk);
      chk("R5 adv low holds word", dq, model[33]);
      adv = 1;
      @(posedge clk); @(negedge clk);
      adv = 0;
      chk("R5 adv high steps once", dq, model[34]);
   endtask

   task automatic t_gate_select();
      rd_word(40, "R10 read before gating test");
      @(negedge clk); idle(); oe = 1; cen_a = 0; cpu_start = 1; addr = 6'd50;
      @(posedge clk); @(negedge clk); idle();
      chk("R2 gated processor strobe ignored", dq, model[40]);
      cen_b = 0; ctl_start = 1; addr = 6'd50; gwrite = 1; tb_dq = 18'h0DEAD & 18'h3FFFF; tb_drv = 1;
      @(posedge clk); @(negedge clk); idle(); oe = 1; adv = 1;
      #1 chk("R7 deselected start releases bus", dq, ZZ);
      @(posedge clk); @(negedge clk); adv = 0;
      chk("R7 adv ignored while deselected", dq, ZZ);
      rd_word(50, "R7 deselected write left word intact");
   endtask

   task automatic t_override();
      @(negedge clk); idle(); oe = 1; burst_mode = 0; ctl_start = 1; addr = 6'd44;
      @(posedge clk); @(negedge clk); idle(); adv = 1;
      @(posedge clk); @(negedge clk);
      chk("R6 first burst stepped", dq, model[45]);
      cpu_start = 1; addr = 6'd14;
      @(posedge clk); @(negedge clk); idle(); adv = 1;
      chk("R6 new strobe restarts", dq, model[14]);
      @(posedge clk); @(negedge clk); adv = 0;
      chk("R6 restarted burst steps from new base", dq, model[15]);
   endtask

   task automatic t_lanes();
      wr_word(7, 18'h3FFFF, 0, 1, 2'b01);
      oe = 1;
      #1 chk("R10 bus released after write", dq, ZZ);
      rd_word(7, "R9 lane 0 only");
      wr_word(9, 18'h15555, 0, 1, 2'b10);
      rd_word(9, "R9 lane 1 only");
      wr_word(11, 18'h2ABCD, 1, 0, 2'b00);
      rd_word(11, "R8 global write both lanes");
      // bwe low and gwrite low: a read, bus driven only by the bench
      @(negedge clk); idle(); oe = 0; ctl_start = 1; addr = 6'd12;
      lane_sel = 2'b11; tb_dq = 18'h00001; tb_drv = 1;
      @(posedge clk); @(negedge clk); idle();
      rd_word(12, "R9 no write without bwe");
   endtask

   task automatic t_burst_write();
      logic [W-1:0] d;
      @(negedge clk); idle(); oe = 0; burst_mode = 1; ctl_start = 1;
      addr = 6'd58; gwrite = 1; d = 18'h11111; tb_dq = d; tb_drv = 1;
      @(posedge clk); model_wr(58, d, 1, 0, 2'b00);
      for (int k = 1; k < 4; k++) begin
         @(negedge clk); ctl_start = 0; adv = 1; d = d + 18'h01234; tb_dq = d;
         @(posedge clk); model_wr(56 + (2 ^ k), d, 1, 0, 2'b00);
      end
      @(negedge clk); idle();
      rd_burst(58, 1, 0);
   endtask

   task automatic t_oe();
      rd_word(5, "R10 read before oe test");
      #3 oe = 0;
      #1 chk("R11 oe low releases at once", dq, ZZ);
      oe = 1;
      #1 chk("R11 oe high drives again", dq, model[5]);
   endtask

   task automatic t_sleep();
      rd_word(3, "R10 read before sleep");
      @(negedge clk); idle(); oe = 1; sleep = 1; ctl_start = 1; addr = 6'd3;
      gwrite = 1; tb_dq = 18'h3C3C3; tb_drv = 1;
      @(posedge clk); @(negedge clk); idle();
      #1 chk("R12 bus released in sleep", dq, ZZ);
      sleep = 0;
      #1 chk("R12 read word kept across sleep", dq, model[3]);
      rd_word(3, "R12 write in sleep ignored");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      t_reset();
      t_fill();
      t_orders();
      t_hold();
      t_gate_select();
      t_override();
      t_lanes();
      t_burst_write();
      t_oe();
      t_sleep();
      done = 1;
   end

   initial begin
      for (int c = 0; c < 50000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hung expected finished");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule